// File: doc/BRIEF.md
# Arithmetic Status Flags and Condition Gate

This unit sits beside the integer adder of a simple processor datapath. Each cycle it takes two operands and an operation select, and it presents the sum or difference combinationally. It also works out the negative, zero, carry and overflow flags that the operation would produce. When the flag-setting input is high and the instruction's condition holds, those four flags are loaded into a status register on the next rising clock edge.

A 4-bit condition code is tested against the flags already held in the status register. The result is an execute-enable, which the surrounding pipeline uses as its write strobe. This lets short forward branches be replaced by predicated instructions. The unit also has a move operation, which passes the first operand through and refreshes only the negative and zero flags.

Top module: `fcu_flag_unit`

## Requirements
- R1: Status word bit 31 holds N, loaded with bit 31 of the result.
- R2: Status word bit 30 holds Z, loaded as 1 exactly when the whole result is zero.
- R3: Status word bit 29 holds C. For additions, C is the unsigned carry out of the top bit. `op_sel` 000 adds with no carry, 001 adds the stored C, and 100 adds the `carry_in` port.
- R4: For subtractions, C is 1 when no borrow occurred and 0 on a borrow. `op_sel` 010 subtracts. 011 subtracts with the stored C, and 101 subtracts with `carry_in`. In both carry forms a carry of 0 takes away one extra.
- R5: Status word bit 28 holds V, which marks signed two's-complement overflow of the add or subtract.
- R6: `exec_en` decodes `cond_code` against the stored flags as follows: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V).
- R7: Code 1110 always gives `exec_en`=1, and code 1111 always gives 0.
- R8: The flags change only on a rising edge where `set_flags` is 1 and `exec_en` is 1. Otherwise all four flags hold their value.
- R9: `op_sel` 110 and 111 are moves. The result equals `opnd_a`, N and Z follow it, and C and V keep their stored values.
- R10: A synchronous active-high `rst` clears the status word to zero.
- R11: `result` is combinational from the operands, the operation and the stored C, and is valid in the same cycle whatever the condition. Status word bits 27:0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation select |
| carry_in | input | 1 | External carry for op_sel 100 and 101 |
| set_flags | input | 1 | Request to load flags |
| cond_code | input | 4 | Condition field of the instruction |
| result | output | 32 | Sum, difference or moved operand |
| status_word | output | 32 | Flags in bits 31:28, zero elsewhere |
| exec_en | output | 1 | Condition passed |

## Verification
A wrongly loaded flag appears on `status_word` one cycle after the operation that set it. From that cycle on it also skews `exec_en` for any condition that reads the flag. The bench sweeps every operation over signed and unsigned boundary operands with both stored carries. After each step it tests all sixteen condition codes, so a corrupt flag is caught within two cycles of the edge that stored it. A spurious load under a failing condition shows up as a status change on the following cycle.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    localparam int STATUS_W = 32;
    localparam int FLAGS_W  = 4;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADC   = 3'd1,
        OP_SUB   = 3'd2,
        OP_SBC   = 3'd3,
        OP_ADDX  = 3'd4,
        OP_SUBX  = 3'd5,
        OP_MOVE  = 3'd6,
        OP_MOVE2 = 3'd7
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic is_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_SUBX);
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op != OP_MOVE) && (op != OP_MOVE2);
    endfunction

    // Conditions come in true/inverse pairs; bit 0 selects the inverse.
    function automatic logic cond_holds(cond_e cc, nzcv_t f);
        logic base;
        case (cc[3:1])
            3'd0:    base = f.z;
            3'd1:    base = f.c;
            3'd2:    base = f.n;
            3'd3:    base = f.v;
            3'd4:    base = f.c & ~f.z;
            3'd5:    base = (f.n == f.v);
            3'd6:    base = ~f.z & (f.n == f.v);
            default: base = 1'b1;
        endcase
        return base ^ cc[0];
    endfunction

endpackage

// File: rtl/fcu_arith.sv
module fcu_arith
    import fcu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         carry_in,
    input  nzcv_t        flags_q,
    output logic [W-1:0] result,
    output nzcv_t        flags_d
);
    localparam int SUM_W = W + 1;

    logic [W-1:0]     b_eff;
    logic             cin;
    logic [SUM_W-1:0] sum;
    logic             arith;

    always_comb begin
        arith = is_arith(op);
        b_eff = is_subtract(op) ? ~b : b;
        case (op)
            OP_ADD:         cin = 1'b0;
            OP_SUB:         cin = 1'b1;
            OP_ADC, OP_SBC: cin = flags_q.c;
            default:        cin = carry_in;
        endcase
        sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        result = arith ? sum[W-1:0] : a;

        flags_d.n = result[W-1];
        flags_d.z = (result == '0);
        flags_d.c = arith ? sum[W] : flags_q.c;
        flags_d.v = arith ? ((a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]))
                          : flags_q.v;
    end
endmodule

// File: rtl/fcu_cond.sv
module fcu_cond
    import fcu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cond_e cc,
    input  nzcv_t flags,
    output logic  pass
);
    always_comb pass = cond_holds(cc, flags);

    assert_never_R7: assert property (@(posedge clk) disable iff (rst)
        (cc == CC_NV) |-> !pass);
    assert_always_R7: assert property (@(posedge clk) disable iff (rst)
        (cc == CC_AL) |-> pass);
    assert_pl_R6: assert property (@(posedge clk) disable iff (rst)
        (cc == CC_PL) |-> (pass == !flags.n));
endmodule

// File: rtl/fcu_status.sv
module fcu_status
    import fcu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  nzcv_t d,
    output nzcv_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |-> $stable(q));
    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (q == '0));
endmodule

// File: rtl/fcu_flag_unit.sv
module fcu_flag_unit
    import fcu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        opnd_a,
    input  logic [W-1:0]        opnd_b,
    input  logic [2:0]          op_sel,
    input  logic                carry_in,
    input  logic                set_flags,
    input  logic [3:0]          cond_code,
    output logic [W-1:0]        result,
    output logic [STATUS_W-1:0] status_word,
    output logic                exec_en
);
    localparam int LOW_W = STATUS_W - FLAGS_W;

    nzcv_t flags_q;
    nzcv_t flags_d;
    logic  load;

    fcu_arith #(.W(W)) arith_i (
        .a        (opnd_a),
        .b        (opnd_b),
        .op       (alu_op_e'(op_sel)),
        .carry_in (carry_in),
        .flags_q  (flags_q),
        .result   (result),
        .flags_d  (flags_d)
    );

    fcu_cond cond_i (
        .clk   (clk),
        .rst   (rst),
        .cc    (cond_e'(cond_code)),
        .flags (flags_q),
        .pass  (exec_en)
    );

    assign load = set_flags & exec_en;

    fcu_status status_i (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (flags_d),
        .q    (flags_q)
    );

    assign status_word = {flags_q, {LOW_W{1'b0}}};

    assert_neg_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> (status_word[31] == $past(result[W-1])));
    assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> (status_word[30] == ($past(result) == '0)));
    assert_move_keeps_cv_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load) && $past(op_sel[2:1] == 2'b11))
            |-> (status_word[29:28] == $past(status_word[29:28])));
endmodule

// File: tb/fcu_flag_unit_tb.sv
module fcu_flag_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic        carry_in = 1'b0, set_flags = 1'b0;
    logic [3:0]  cond_code = 4'd14;
    logic [31:0] result, status_word;
    logic        exec_en;

    int checks = 0;
    int errors = 0;
    logic [3:0] mf = 4'b0000; // model flags {n,z,c,v}

    always #(CLK_PERIOD/2) clk = ~clk;

    fcu_flag_unit dut_i (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .carry_in(carry_in), .set_flags(set_flags),
        .cond_code(cond_code), .result(result), .status_word(status_word),
        .exec_en(exec_en)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_cond(input int cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            0: return z;            1: return !z;
            2: return c;            3: return !c;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return c && !z;      9: return !c || z;
            10: return n == v;      11: return n != v;
            12: return !z && (n == v); 13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input logic [31:0] a, input logic [31:0] b, input int op,
                        input logic cin, input logic sf, input int cc);
        longint ua, ub, sa, sb, ci, ur, sr;
        logic [31:0] er;
        logic [3:0]  ef;
        logic        pe, sub;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = 3'(op); carry_in = cin;
        set_flags = sf; cond_code = 4'(cc);
        #1;
        ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
        sa = longint'($signed(a)); sb = longint'($signed(b));
        sub = (op == 2) || (op == 3) || (op == 5);
        if (op == 0) ci = 0;
        else if (op == 2) ci = 1;
        else if (op == 1 || op == 3) ci = longint'(mf[1]);
        else ci = longint'(cin);
        ef = mf;
        if (op >= 6) begin
            er = a;
        end else if (sub) begin
            ur = ua - ub - (1 - ci); sr = sa - sb - (1 - ci);
            er = ur[31:0];
            ef[1] = (ur >= 0);
            ef[0] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end else begin
            ur = ua + ub + ci; sr = sa + sb + ci;
            er = ur[31:0];
            ef[1] = (ur >= 64'sd4294967296);
            ef[0] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end
        ef[3] = er[31];
        ef[2] = (er == 32'd0);
        pe = exp_cond(cc, mf);
        check(result == er, "R11 result", result, er);
        check(exec_en == pe, (cc >= 14) ? "R7 exec_en" : "R6 exec_en", {31'd0, exec_en}, {31'd0, pe});
        @(posedge clk); #1;
        if (sf && pe) begin
            mf = ef;
            check(status_word[31] == mf[3], "R1 N", status_word, {mf, 28'd0});
            check(status_word[30] == mf[2], "R2 Z", status_word, {mf, 28'd0});
            check(status_word[29] == mf[1], op >= 6 ? "R9 C" : (sub ? "R4 C" : "R3 C"), status_word, {mf, 28'd0});
            check(status_word[28] == mf[0], op >= 6 ? "R9 V" : "R5 V", status_word, {mf, 28'd0});
        end else begin
            check(status_word[31:28] == mf, "R8 hold", status_word, {mf, 28'd0});
        end
        check(status_word[27:0] == 28'd0, "R11 low bits", status_word, {mf, 28'd0});
    endtask

    localparam int NV = 8;
    logic [31:0] vals [NV] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678, 32'hFFFF_FFFE};

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(status_word == 32'd0, "R10 reset", status_word, 32'd0);
        @(negedge clk); rst = 1'b0;
        // Pass 1: every op over boundary operands, both carry inputs, flags set.
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++)
                for (int op = 0; op < 8; op++)
                    for (int k = 0; k < 2; k++)
                        step(vals[i], vals[j], op, k[0], 1'b1, 14);
        // Pass 2: every condition code against the flags left by each op.
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++)
                for (int op = 0; op < 6; op++) begin
                    step(vals[i], vals[j], op, 1'b1, 1'b1, 14);
                    for (int cc = 0; cc < 16; cc++)
                        step(vals[j], vals[i], (op + cc) % 8, cc[0], cc[1], cc);
                end
        // R8: set_flags low leaves flags alone even on a zero result.
        step(32'd5, 32'd5, 2, 1'b0, 1'b0, 14);
        // R7: never-code with set_flags high must not load.
        step(32'h8000_0000, 32'h8000_0000, 0, 1'b0, 1'b1, 15);
        // R4: borrow chain, stored C=0 subtracts one extra.
        step(32'd0, 32'd1, 2, 1'b0, 1'b1, 14);
        step(32'd10, 32'd3, 3, 1'b0, 1'b1, 14);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule